// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Initialisation

This block keeps an asynchronous DRAM refreshed and brings it out of power-up. Once reset is released, it waits a fixed settling pause and then runs eight refresh cycles. Only after both steps are finished does it raise `ready`, which tells the rest of the memory subsystem that normal accesses may begin. From then on an interval timer requests one refresh every `INTERVAL_CYC` clocks. With the default settings at 250 MHz, this spreads 1,024 refreshes evenly over 16 ms, about one every 15.6 µs.

The block owns the RAS and CAS strobes and the row address lines only while it holds the bus. It asks for the bus with `bus_req` and waits for `bus_gnt` from the access controller. It does not drop `bus_req` until all of its outstanding refreshes are done.

Two refresh forms are available, chosen by `mode_ras_only` and sampled when the bus is granted:
- **CAS-before-RAS:** all CAS lanes go low before RAS falls, and the memory supplies its own row.
- **RAS-only:** CAS stays high and the block drives its own 10-bit row counter onto the address lines.

Refreshes that cannot be issued because the grant is late are counted, up to a limit. When the grant arrives they are issued back to back.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it: `ready` is 0, `bus_req` is 0, `ras_n` is 1, every `cas_n` lane is 1 and `addr` is 0.
- R2: `bus_req` stays low for at least `PAUSE_CYC` cycles after reset is released.
- R3: After the pause, exactly `INIT_REFRESHES` (8) refresh cycles are issued before `ready` rises. `ready` then stays high until the next reset.
- R4: `ras_n` goes low only while `bus_req` and `bus_gnt` are both high. While the grant is withheld, no refresh cycle starts and `ras_n` stays high.
- R5: Once `ready` is high, the interval timer asks for one refresh every `INTERVAL_CYC` cycles. With an immediate grant, consecutive falling edges of `ras_n` are exactly `INTERVAL_CYC` cycles apart.
- R6: In CAS-before-RAS form (`mode_ras_only` = 0 at grant):
  - every `cas_n` lane is low for at least `T_SET` cycles before `ras_n` falls;
  - the lanes stay low until `ras_n` rises;
  - `addr` reads 0.
- R7: In RAS-only form (`mode_ras_only` = 1 at grant):
  - every `cas_n` lane stays high for the whole cycle;
  - `addr` carries the row counter and is stable while `ras_n` is low.
- R8: The row counter is 0 after reset. It advances by one after each RAS-only refresh, wraps from 1023 to 0, and is left unchanged by CAS-before-RAS refreshes.
- R9: Each refresh holds `ras_n` low for exactly `T_RAS` cycles, and `ras_n` is high for at least `T_RP` cycles between two refreshes.
- R10: Missed refresh requests accumulate up to `MAX_PEND` (8); further ones are dropped. On grant, all pending refreshes are issued back to back with `bus_req` held high, and `bus_req` is then released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ras_only | input | 1 | 1: RAS-only refresh from the internal row counter; 0: CAS-before-RAS |
| bus_gnt | input | 1 | Bus grant from the access controller |
| bus_req | output | 1 | Bus request, held from the request through the last queued refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_LANES | Column strobes for each byte lane, active low, driven together |
| addr | output | ROW_W | Row address during RAS-only refresh, otherwise 0 |
| ready | output | 1 | High once the power-up pause and the initial refreshes are complete |

## Verification
The assertions check the following on every cycle:
- the strobe-to-request relation and the silence during the pause;
- `ready` staying high once set, and the pending count staying within its bound;
- CAS being low when RAS falls in CAS-before-RAS form, and high throughout RAS-only form;
- the address staying stable under a low RAS, and the exact low time of RAS.

Other behaviour only the bench scenarios can show:
- that exactly eight initial refreshes come before `ready`;
- that timer spacing matches the interval;
- that a withheld grant collects a saturated backlog which then drains back to back;
- that the RAS-only row sequence wraps from 1023 to 0.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_REQ    = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_PRECH  = 3'd4
    } rf_state_e;

    typedef enum logic {
        RF_CBR = 1'b0,
        RF_ROW = 1'b1
    } rf_mode_e;

    typedef struct packed {
        logic req;
        logic ras_n;
        logic cas_n;
        logic drive_row;
    } rf_pins_t;

    // bits needed to hold values 0..max_val
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    // strobe/request levels for each sequencer state
    function automatic rf_pins_t pins_for(input rf_state_e st, input rf_mode_e m);
        rf_pins_t p;
        p.req       = 1'b0;
        p.ras_n     = 1'b1;
        p.cas_n     = 1'b1;
        p.drive_row = 1'b0;
        case (st)
            ST_REQ: p.req = 1'b1;
            ST_SETUP: begin
                p.req       = 1'b1;
                p.cas_n     = (m == RF_ROW);
                p.drive_row = (m == RF_ROW);
            end
            ST_STROBE: begin
                p.req       = 1'b1;
                p.ras_n     = 1'b0;
                p.cas_n     = (m == RF_ROW);
                p.drive_row = (m == RF_ROW);
            end
            ST_PRECH: p.req = 1'b1;
            default: p.req = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rf_interval_timer.sv
`timescale 1ns/1ps
module rf_interval_timer
    import rfsh_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC = 3900
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = cnt_width(INTERVAL_CYC - 1);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/rf_powerup_seq.sv
`timescale 1ns/1ps
module rf_powerup_seq
    import rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC      = 50000,
    parameter int unsigned INIT_REFRESHES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic refresh_done,
    output logic pause_done,
    output logic init_load,
    output logic ready
);
    localparam int unsigned PW = cnt_width(PAUSE_CYC);
    localparam int unsigned IW = cnt_width(INIT_REFRESHES);
    localparam logic [PW-1:0] P_LAST = PW'(PAUSE_CYC - 1);

    logic [PW-1:0] p_cnt_q;
    logic          p_done_q;
    logic [IW-1:0] left_q;

    assign init_load = !p_done_q && (p_cnt_q == P_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            p_cnt_q  <= '0;
            p_done_q <= 1'b0;
        end else if (!p_done_q) begin
            if (init_load) begin
                p_done_q <= 1'b1;
            end else begin
                p_cnt_q <= p_cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (init_load) begin
            left_q <= IW'(INIT_REFRESHES);
        end else if (refresh_done && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign pause_done = p_done_q;
    assign ready      = p_done_q && (left_q == '0);
endmodule

// File: rtl/rf_pending_ctr.sv
`timescale 1ns/1ps
module rf_pending_ctr #(
    parameter int unsigned MAX_PEND  = 8,
    parameter int unsigned INIT_LOAD = 8,
    parameter int unsigned PEND_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              tick,
    input  logic              done,
    output logic [PEND_W-1:0] pend,
    output logic              pend_nz,
    output logic              pend_more
);
    logic [PEND_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (load) begin
            pend_q <= PEND_W'(INIT_LOAD);
        end else begin
            case ({tick, done})
                2'b10: if (pend_q != PEND_W'(MAX_PEND)) pend_q <= pend_q + 1'b1;
                2'b01: if (pend_q != '0) pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign pend      = pend_q;
    assign pend_nz   = (pend_q != '0);
    assign pend_more = (pend_q > PEND_W'(1));
endmodule

// File: rtl/rf_row_ctr.sv
`timescale 1ns/1ps
module rf_row_ctr #(
    parameter int unsigned ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (adv) begin
            row_q <= row_q + 1'b1;
        end
    end

    assign row = row_q;
endmodule

// File: rtl/rf_cycle_fsm.sv
`timescale 1ns/1ps
module rf_cycle_fsm
    import rfsh_pkg::*;
#(
    parameter int unsigned T_SET = 3,
    parameter int unsigned T_RAS = 13,
    parameter int unsigned T_RP  = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pend_nz,
    input  logic     pend_more,
    input  logic     bus_gnt,
    input  rf_mode_e mode_sel,
    output rf_pins_t pins,
    output logic     done,
    output rf_mode_e mode_lat
);
    localparam int unsigned MAX_A  = (T_SET > T_RP) ? T_SET : T_RP;
    localparam int unsigned PH_MAX = (T_RAS > MAX_A) ? T_RAS : MAX_A;
    localparam int unsigned PHW    = cnt_width(PH_MAX);
    localparam logic [PHW-1:0] SET_LAST = PHW'(T_SET - 1);
    localparam logic [PHW-1:0] RAS_LAST = PHW'(T_RAS - 1);
    localparam logic [PHW-1:0] RP_LAST  = PHW'(T_RP - 1);

    rf_state_e      state_q;
    logic [PHW-1:0] ph_q;
    rf_mode_e       mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            mode_q  <= RF_CBR;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (pend_nz) state_q <= ST_REQ;
                end
                ST_REQ: begin
                    if (bus_gnt) begin
                        state_q <= ST_SETUP;
                        ph_q    <= SET_LAST;
                        mode_q  <= mode_sel;
                    end
                end
                ST_SETUP: begin
                    if (ph_q == '0) begin
                        state_q <= ST_STROBE;
                        ph_q    <= RAS_LAST;
                    end else begin
                        ph_q <= ph_q - 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (ph_q == '0) begin
                        state_q <= ST_PRECH;
                        ph_q    <= RP_LAST;
                    end else begin
                        ph_q <= ph_q - 1'b1;
                    end
                end
                ST_PRECH: begin
                    if (ph_q == '0) begin
                        if (pend_more && bus_gnt) begin
                            state_q <= ST_SETUP;
                            ph_q    <= SET_LAST;
                            mode_q  <= mode_sel;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else begin
                        ph_q <= ph_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done     = (state_q == ST_PRECH) && (ph_q == '0);
    assign pins     = pins_for(state_q, mode_q);
    assign mode_lat = mode_q;
endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched
    import rfsh_pkg::*;
#(
    parameter int unsigned INTERVAL_CYC   = 3900,
    parameter int unsigned PAUSE_CYC      = 50000,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned MAX_PEND       = 8,
    parameter int unsigned ROW_W          = 10,
    parameter int unsigned CAS_LANES      = 2,
    parameter int unsigned T_SET          = 3,
    parameter int unsigned T_RAS          = 13,
    parameter int unsigned T_RP           = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_ras_only,
    input  logic                 bus_gnt,
    output logic                 bus_req,
    output logic                 ras_n,
    output logic [CAS_LANES-1:0] cas_n,
    output logic [ROW_W-1:0]     addr,
    output logic                 ready
);
    localparam int unsigned PEND_W = cnt_width(MAX_PEND);

    logic              tick;
    logic              pause_done;
    logic              init_load;
    logic              refresh_done;
    logic [PEND_W-1:0] pend;
    logic              pend_nz;
    logic              pend_more;
    logic [ROW_W-1:0]  row;
    rf_pins_t          pins;
    rf_mode_e          mode_lat;
    rf_mode_e          mode_sel;

    assign mode_sel = rf_mode_e'(mode_ras_only);

    rf_powerup_seq #(
        .PAUSE_CYC      (PAUSE_CYC),
        .INIT_REFRESHES (INIT_REFRESHES)
    ) u_pwrup (
        .clk          (clk),
        .rst          (rst),
        .refresh_done (refresh_done),
        .pause_done   (pause_done),
        .init_load    (init_load),
        .ready        (ready)
    );

    rf_interval_timer #(
        .INTERVAL_CYC (INTERVAL_CYC)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (ready),
        .tick (tick)
    );

    rf_pending_ctr #(
        .MAX_PEND  (MAX_PEND),
        .INIT_LOAD (INIT_REFRESHES),
        .PEND_W    (PEND_W)
    ) u_pend (
        .clk       (clk),
        .rst       (rst),
        .load      (init_load),
        .tick      (tick),
        .done      (refresh_done),
        .pend      (pend),
        .pend_nz   (pend_nz),
        .pend_more (pend_more)
    );

    rf_cycle_fsm #(
        .T_SET (T_SET),
        .T_RAS (T_RAS),
        .T_RP  (T_RP)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pend_nz   (pend_nz),
        .pend_more (pend_more),
        .bus_gnt   (bus_gnt),
        .mode_sel  (mode_sel),
        .pins      (pins),
        .done      (refresh_done),
        .mode_lat  (mode_lat)
    );

    rf_row_ctr #(
        .ROW_W (ROW_W)
    ) u_row (
        .clk (clk),
        .rst (rst),
        .adv (refresh_done && (mode_lat == RF_ROW)),
        .row (row)
    );

    assign bus_req = pins.req;
    assign ras_n   = pins.ras_n;
    assign addr    = pins.drive_row ? row : '0;

    for (genvar g = 0; g < CAS_LANES; g++) begin : g_cas_lane
        assign cas_n[g] = pins.cas_n;
    end
endmodule

// File: rtl/rf_sched_checker.sv
`timescale 1ns/1ps
module rf_sched_checker #(
    parameter int unsigned T_RAS     = 13,
    parameter int unsigned MAX_PEND  = 8,
    parameter int unsigned PEND_W    = 4,
    parameter int unsigned ROW_W     = 10,
    parameter int unsigned CAS_LANES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ras_n,
    input logic [CAS_LANES-1:0] cas_n,
    input logic                 bus_req,
    input logic                 ready,
    input logic [ROW_W-1:0]     addr,
    input logic                 pause_done,
    input logic [PEND_W-1:0]    pend,
    input logic                 mode_lat
);
    logic [15:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) lo_cnt <= '0;
        else if (!ras_n) lo_cnt <= lo_cnt + 1'b1;
        else lo_cnt <= '0;
    end

    assert_strobe_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> bus_req);

    assert_quiet_in_pause_R2: assert property (@(posedge clk) disable iff (rst)
        !pause_done |-> !bus_req);

    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    assert_pend_bound_R10: assert property (@(posedge clk) disable iff (rst)
        pend <= PEND_W'(MAX_PEND));

    assert_cas_leads_ras_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !mode_lat) |-> ((cas_n == '0) && ($past(cas_n) == '0)));

    assert_cas_idle_rowmode_R7: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && mode_lat) |-> (cas_n == '1));

    assert_row_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && $past(!ras_n)) |-> $stable(addr));

    assert_ras_width_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (lo_cnt == 16'(T_RAS)));
endmodule

bind dram_refresh_sched rf_sched_checker #(
    .T_RAS     (T_RAS),
    .MAX_PEND  (MAX_PEND),
    .PEND_W    (PEND_W),
    .ROW_W     (ROW_W),
    .CAS_LANES (CAS_LANES)
) u_rf_chk (
    .clk        (clk),
    .rst        (rst),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .bus_req    (bus_req),
    .ready      (ready),
    .addr       (addr),
    .pause_done (pause_done),
    .pend       (pend),
    .mode_lat   (mode_lat)
);

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
    localparam int INTERVAL = 100;
    localparam int PAUSE    = 40;
    localparam int T_SET    = 2;
    localparam int T_RAS    = 3;
    localparam int T_RP     = 2;

    typedef struct packed {
        logic        ro;
        int unsigned delay;
        int unsigned exp_falls;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 32'd0,   32'd1},
        '{1'b1, 32'd3,   32'd1},
        '{1'b0, 32'd10,  32'd1},
        '{1'b1, 32'd0,   32'd1},
        '{1'b1, 32'd105, 32'd2},
        '{1'b0, 32'd5,   32'd1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0;
    logic       gnt_auto = 1'b0;
    logic       gnt_man = 1'b0;
    logic       bus_gnt;
    logic       bus_req;
    logic       ras_n;
    logic [1:0] cas_n;
    logic [9:0] addr;
    logic       ready;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign bus_gnt = gnt_auto ? bus_req : gnt_man;

    dram_refresh_sched #(
        .INTERVAL_CYC   (INTERVAL),
        .PAUSE_CYC      (PAUSE),
        .INIT_REFRESHES (8),
        .MAX_PEND       (8),
        .ROW_W          (10),
        .CAS_LANES      (2),
        .T_SET          (T_SET),
        .T_RAS          (T_RAS),
        .T_RP           (T_RP)
    ) i_dram_refresh_sched (
        .clk           (clk),
        .rst           (rst),
        .mode_ras_only (mode),
        .bus_gnt       (bus_gnt),
        .bus_req       (bus_req),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .addr          (addr),
        .ready         (ready)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // bus monitor sampled on the falling edge
    int   cyc = 0;
    int   falls = 0;
    int   ro_falls = 0;
    int   lo_run = 0;
    int   hi_run = 0;
    int   cas_lo_run = 0;
    int   last_fall = 0;
    int   last_gap = 0;
    int   exp_row = 0;
    int   last_ro_addr = -1;
    int   prev_ro_addr = -1;
    logic prev_ras = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst) begin
            prev_ras   = 1'b1;
            lo_run     = 0;
            hi_run     = 0;
            cas_lo_run = 0;
        end else begin
            if (prev_ras && !ras_n) begin
                falls++;
                last_gap  = cyc - last_fall;
                last_fall = cyc;
                if (falls > 1) chk(hi_run >= T_RP, "R9 precharge", hi_run, T_RP);
                if (!mode) begin
                    chk(cas_n == 2'b00 && cas_lo_run >= T_SET, "R6 cas setup", cas_lo_run, T_SET);
                    chk(addr == 10'd0, "R6 addr", addr, 0);
                end else begin
                    chk(cas_n == 2'b11, "R7 cas high", cas_n, 3);
                    chk(addr == exp_row[9:0], "R8 row", addr, exp_row);
                    prev_ro_addr = last_ro_addr;
                    last_ro_addr = int'(addr);
                    exp_row      = (exp_row + 1) % 1024;
                    ro_falls++;
                end
            end
            if (!prev_ras && ras_n) chk(lo_run == T_RAS, "R9 ras width", lo_run, T_RAS);
            if (!ras_n) begin
                chk(bus_gnt && bus_req, "R4 strobe under grant", {bus_req, bus_gnt}, 3);
                if (mode) chk(cas_n == 2'b11, "R7 cas held", cas_n, 3);
                else      chk(cas_n == 2'b00, "R6 cas held", cas_n, 0);
            end
            lo_run     = !ras_n ? lo_run + 1 : 0;
            hi_run     = ras_n ? hi_run + 1 : 0;
            cas_lo_run = (cas_n == 2'b00) ? cas_lo_run + 1 : 0;
            prev_ras   = ras_n;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "R3 watchdog", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int f0;
        int seen;
        int k;

        repeat (3) @(negedge clk);
        chk({ready, bus_req, ras_n, cas_n} == 5'b00111 && addr == 10'd0, "R1 reset",
            {ready, bus_req, ras_n, cas_n}, 5'b00111);

        // power-up: pause then eight refreshes
        rst = 1'b0;
        gnt_auto = 1'b1;
        n = 0;
        while (!bus_req) begin
            @(negedge clk);
            n++;
        end
        chk(n >= PAUSE && n <= PAUSE + 2, "R2 pause", n, PAUSE + 1);
        chk(!ready, "R3 not ready early", ready, 0);
        while (!ready) @(negedge clk);
        chk(falls == 8, "R3 init count", falls, 8);
        gnt_auto = 1'b0;

        // vector table: mode, grant latency, expected refreshes
        for (int i = 0; i < 6; i++) begin
            mode = VECS[i].ro;
            while (!bus_req) @(negedge clk);
            f0 = falls;
            for (int d = 0; d < int'(VECS[i].delay); d++) @(negedge clk);
            chk(falls == f0 && ras_n, "R4 held off", falls - f0, 0);
            gnt_man = 1'b1;
            @(negedge clk);
            while (bus_req) @(negedge clk);
            gnt_man = 1'b0;
            chk(falls - f0 == int'(VECS[i].exp_falls), "R10 per vector", falls - f0, VECS[i].exp_falls);
        end
        chk(ready, "R3 ready sticky", ready, 1);

        // backlog saturation and back-to-back drain
        mode = 1'b0;
        while (!bus_req) @(negedge clk);
        f0 = falls;
        repeat (11 * INTERVAL + 5) @(negedge clk);
        chk(falls == f0 && ras_n, "R4 no grant no strobe", falls - f0, 0);
        gnt_man = 1'b1;
        @(negedge clk);
        while (bus_req) @(negedge clk);
        gnt_man = 1'b0;
        chk(falls - f0 == 8, "R10 saturated backlog", falls - f0, 8);

        // periodic RAS-only refresh through the row wrap
        mode = 1'b1;
        gnt_auto = 1'b1;
        seen = falls;
        k = 0;
        while (ro_falls < 1025) begin
            @(negedge clk);
            if (falls != seen) begin
                seen = falls;
                k++;
                if (k > 2) chk(last_gap == INTERVAL, "R5 interval", last_gap, INTERVAL);
            end
        end
        chk(prev_ro_addr == 1023 && last_ro_addr == 0, "R8 wrap", last_ro_addr, 0);
        chk(ready, "R3 still ready", ready, 1);

        // reset in mid operation
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk({ready, bus_req, ras_n, cas_n} == 5'b00111 && addr == 10'd0, "R1 re-reset",
            {ready, bus_req, ras_n, cas_n}, 5'b00111);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule